// File: doc/BRIEF.md
# Sleep Request Power-Down Controller

This block sits beside a synchronous, pipelined memory and turns an asynchronous, active-high sleep request into clean, clock-aligned control. The request first passes through a synchroniser. After a fixed entry window, the controller closes the gate on all synchronous command inputs and forces the data outputs to high impedance. It also raises a low-power status flag for the power logic.

When the request drops, the low-power status clears at once. Inputs come back only through a short recovery window. In that window reads and deselects are accepted, and any write is refused and flagged. A second flag reports a sleep request that lands while a read or write is still travelling through the memory pipeline, because such an operation may be lost.

Commands arrive on a two-bit code. The controller qualifies them into read-accept and write-accept strobes that the memory core uses as its only enables.

Top module: `snz_ctrl`

## Requirements
- R1: After reset, input_enable_o is 1, and output_disable_o, low_power_o, recovery_o, wake_violation_o and pending_abort_o are all 0.
- R2: Take n as the first clock edge that samples sleep_i high while the block is awake. Inputs stay enabled through edge n+3. input_enable_o falls to 0 and output_disable_o rises to 1 after edge n+4, which covers two synchroniser stages and two entry cycles.
- R3: low_power_o rises in the same cycle that input_enable_o falls. Take m as the first edge that samples sleep_i low while asleep. low_power_o returns to 0 after edge m+1, while inputs are still disabled.
- R4: While inputs are disabled, rd_accept_o and wr_accept_o stay 0 for every cmd_i value, including read (2'b01) and write (2'b10).
- R5: recovery_o is 1 for exactly two cycles, after edges m+2 and m+3. During those cycles input_enable_o is 1, output_disable_o is 0 and a read (cmd_i = 2'b01) gives rd_accept_o = 1. recovery_o is 0 again after edge m+4.
- R6: A write (cmd_i = 2'b10) during recovery sets wake_violation_o to 1 in the same cycle and keeps wr_accept_o at 0.
- R7: While awake, a write (cmd_i = 2'b10) gives wr_accept_o = 1 and a read (cmd_i = 2'b01) gives rd_accept_o = 1. Neither sets wake_violation_o. Deselect is 2'b00 and 2'b11 is a no-op.
- R8: pending_abort_o is 1 for one cycle when the synchronised request is first seen high while awake and an accepted read or write is less than two cycles old. With no operation in flight it stays 0.
- R9: If the synchronised request rises again during recovery, the block leaves recovery on the next edge. It re-enters sleep two cycles later, with low_power_o at 1 and input_enable_o at 0.
- R10: A request that disappears during the entry window returns the block to awake without ever disabling inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Asynchronous sleep request, active high, tie low if unused |
| cmd_i | input | 2 | Command code: 00 deselect, 01 read, 10 write, 11 no-op |
| input_enable_o | output | 1 | Synchronous inputs are honoured |
| output_disable_o | output | 1 | Force data outputs to high impedance |
| low_power_o | output | 1 | Low-power status |
| recovery_o | output | 1 | Wake-up recovery window active |
| rd_accept_o | output | 1 | Read command accepted this cycle |
| wr_accept_o | output | 1 | Write command accepted this cycle |
| wake_violation_o | output | 1 | Write attempted during recovery |
| pending_abort_o | output | 1 | Sleep request hit an operation in flight |

## Verification
Two functions can act in the same cycle: the write-violation check in the recovery window, and the decision to re-enter sleep. The bench provokes this by dropping sleep_i for a single sampled edge. The synchronised request then rises again in the very first recovery cycle, and a write is driven in that cycle. The bench expects the violation flag together with a refused write in that cycle, then the entry window, and then low power two cycles later. A second collision puts a read acceptance in the cycle before the synchronised request rises, and the bench expects the in-flight flag for exactly one cycle.

// File: rtl/snz_pkg.sv
package snz_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2,
    ST_RECOV = 2'd3
  } snz_state_e;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_NOP   = 2'b11
  } snz_cmd_e;
endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= async_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], async_i};
    end
  endgenerate

  assign sync_o = ff_q[STAGES-1];
endmodule

// File: rtl/snz_fsm.sv
module snz_fsm
  import snz_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_s_i,
  output snz_state_e state_o
);
  localparam int MAX_CYC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYC - 1);

  snz_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    unique case (state_q)
      ST_AWAKE: if (sleep_s_i) state_d = ST_ENTER;
      ST_ENTER: begin
        if (!sleep_s_i)                state_d = ST_AWAKE;
        else if (cnt_q == ENTRY_LAST)  state_d = ST_SLEEP;
        else                           cnt_d   = cnt_q + 1'b1;
      end
      ST_SLEEP: if (!sleep_s_i) state_d = ST_RECOV;
      ST_RECOV: begin
        if (sleep_s_i)                 state_d = ST_ENTER;
        else if (cnt_q == EXIT_LAST)   state_d = ST_AWAKE;
        else                           cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end

  assign state_o = state_q;
endmodule

// File: rtl/snz_pipe_trk.sv
module snz_pipe_trk #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  output logic busy_o
);
  logic [DEPTH-1:0] age_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) age_q <= '0;
        else         age_q <= issue_i;
    end else begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) age_q <= '0;
        else         age_q <= {age_q[DEPTH-2:0], issue_i};
    end
  endgenerate

  assign busy_o = |age_q;
endmodule

// File: rtl/snz_ctrl.sv
module snz_ctrl
  import snz_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2,
  parameter int PIPE_DEPTH  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic [1:0] cmd_i,
  output logic       input_enable_o,
  output logic       output_disable_o,
  output logic       low_power_o,
  output logic       recovery_o,
  output logic       rd_accept_o,
  output logic       wr_accept_o,
  output logic       wake_violation_o,
  output logic       pending_abort_o
);
  logic       sleep_s;
  logic       pipe_busy;
  snz_state_e state;
  logic       is_rd, is_wr;

  snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sleep_i),
    .sync_o (sleep_s)
  );

  snz_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_s_i(sleep_s),
    .state_o  (state)
  );

  snz_pipe_trk #(.DEPTH(PIPE_DEPTH)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .issue_i(rd_accept_o | wr_accept_o),
    .busy_o (pipe_busy)
  );

  assign is_rd = (cmd_i == CMD_READ);
  assign is_wr = (cmd_i == CMD_WRITE);

  assign input_enable_o   = (state != ST_SLEEP);
  assign output_disable_o = (state == ST_SLEEP);
  // status drops as soon as the synchronised request does
  assign low_power_o      = (state == ST_SLEEP) && sleep_s;
  assign recovery_o       = (state == ST_RECOV);
  assign rd_accept_o      = input_enable_o && is_rd;
  assign wr_accept_o      = input_enable_o && !recovery_o && is_wr;
  assign wake_violation_o = recovery_o && is_wr;
  assign pending_abort_o  = (state == ST_AWAKE) && sleep_s && pipe_busy;
endmodule

// File: rtl/snz_ctrl_chk.sv
module snz_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_s_i,
  input logic input_enable_o,
  input logic output_disable_o,
  input logic low_power_o,
  input logic recovery_o,
  input logic rd_accept_o,
  input logic wr_accept_o,
  input logic wake_violation_o,
  input logic pending_abort_o
);
  p_gate_before_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(input_enable_o) |-> $past(sleep_s_i));

  p_lp_implies_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_power_o |-> (!input_enable_o && output_disable_o));

  p_no_accept_asleep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !input_enable_o |-> (!rd_accept_o && !wr_accept_o));

  p_recov_from_sleep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recovery_o) |-> $past(output_disable_o));

  p_no_wr_in_recov_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recovery_o |-> !wr_accept_o);

  p_viol_only_recov_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_violation_o |-> recovery_o);

  p_abort_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_abort_o |=> !pending_abort_o);
endmodule

bind snz_ctrl snz_ctrl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .sleep_s_i       (sleep_s),
  .input_enable_o  (input_enable_o),
  .output_disable_o(output_disable_o),
  .low_power_o     (low_power_o),
  .recovery_o      (recovery_o),
  .rd_accept_o     (rd_accept_o),
  .wr_accept_o     (wr_accept_o),
  .wake_violation_o(wake_violation_o),
  .pending_abort_o (pending_abort_o)
);

// File: tb/snz_ctrl_bench.sv
module snz_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0, sleep = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic ien, odis, lp, rec, rda, wra, viol, pab;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snz_ctrl u_snz_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_i(sleep), .cmd_i(cmd),
    .input_enable_o(ien), .output_disable_o(odis), .low_power_o(lp),
    .recovery_o(rec), .rd_accept_o(rda), .wr_accept_o(wra),
    .wake_violation_o(viol), .pending_abort_o(pab)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic go_awake();
    sleep = 1'b0; cmd = 2'b00;
    repeat (8) cyc();
  endtask

  task automatic go_asleep();
    sleep = 1'b1; cmd = 2'b00;
    repeat (6) cyc();
  endtask

  task automatic t_reset();
    chk("R1 ien", ien, 1'b1); chk("R1 odis", odis, 1'b0);
    chk("R1 lp", lp, 1'b0);   chk("R1 rec", rec, 1'b0);
    chk("R1 viol", viol, 1'b0); chk("R1 pab", pab, 1'b0);
  endtask

  task automatic t_awake_cmds();
    cmd = 2'b10; #1;
    chk("R7 wr", wra, 1'b1); chk("R7 viol", viol, 1'b0);
    cmd = 2'b01; #1;
    chk("R7 rd", rda, 1'b1);
    cmd = 2'b11; #1;
    chk("R7 nop rd", rda, 1'b0); chk("R7 nop wr", wra, 1'b0);
    cmd = 2'b00;
    repeat (3) cyc();
  endtask

  task automatic t_entry();
    sleep = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      cyc();
      chk("R2 ien", ien, (k < 5));
      chk("R2 odis", odis, (k >= 5));
      chk("R3 lp", lp, (k >= 5));
    end
    cmd = 2'b10; #1;
    chk("R4 wr", wra, 1'b0); chk("R4 viol", viol, 1'b0);
    cmd = 2'b01; #1;
    chk("R4 rd", rda, 1'b0);
    cmd = 2'b00;
  endtask

  task automatic t_exit();
    sleep = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      cyc();
      case (k)
        1: begin chk("R3 lp hold", lp, 1'b1); chk("R3 ien", ien, 1'b0); end
        2: begin chk("R3 lp clr", lp, 1'b0); chk("R3 ien still off", ien, 1'b0);
                 chk("R5 rec", rec, 1'b0); end
        3: begin
          chk("R5 rec", rec, 1'b1); chk("R5 ien", ien, 1'b1); chk("R5 odis", odis, 1'b0);
          cmd = 2'b10; #1;
          chk("R6 viol", viol, 1'b1); chk("R6 wr", wra, 1'b0);
          cmd = 2'b01; #1;
          chk("R5 rd", rda, 1'b1); chk("R5 rd viol", viol, 1'b0);
          cmd = 2'b00;
        end
        4: chk("R5 rec", rec, 1'b1);
        default: chk("R5 rec end", rec, 1'b0);
      endcase
    end
    repeat (3) cyc();
  endtask

  task automatic t_abort();
    cmd = 2'b01; sleep = 1'b1;
    cyc(); cmd = 2'b00;
    chk("R8 early", pab, 1'b0);
    cyc();
    chk("R8 abort", pab, 1'b1);
    cyc();
    chk("R8 single", pab, 1'b0);
    go_awake();
    sleep = 1'b1;
    cyc(); cyc();
    chk("R8 idle", pab, 1'b0);
    go_awake();
  endtask

  task automatic t_reenter();
    go_asleep();
    sleep = 1'b0; cyc();
    sleep = 1'b1; cyc();
    chk("R9 lp clr", lp, 1'b0);
    cyc();
    chk("R9 rec", rec, 1'b1);
    cmd = 2'b10; #1;
    chk("R9 viol", viol, 1'b1); chk("R9 wr", wra, 1'b0);
    cmd = 2'b00;
    cyc();
    chk("R9 left rec", rec, 1'b0); chk("R9 ien", ien, 1'b1);
    cyc();
    chk("R9 not yet", lp, 1'b0);
    cyc();
    chk("R9 lp", lp, 1'b1); chk("R9 ien off", ien, 1'b0);
    go_awake();
  endtask

  task automatic t_short_pulse();
    sleep = 1'b1; cyc();
    sleep = 1'b0;
    for (int k = 0; k < 8; k++) begin
      cyc();
      chk("R10 ien", ien, 1'b1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_awake_cmds();
    t_entry();
    t_exit();
    t_abort();
    t_reenter();
    t_short_pulse();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule